// File: doc/BRIEF.md
# Banked GPIO Runtime Register File

This block is a byte-wide GPIO controller reached through byte reads and writes at offsets relative to its runtime window. It serves six banks of eight pins. Each bank has one data register. Reading it gives the state of the bank's pins. Writing it loads the bank's output latch in one step, so software changes a single pin by read-modify-write.

Every implemented pin has its own configuration byte. That byte selects the pin's direction, whether its polarity is inverted, and whether its output is open-drain. Some pins are not implemented. Their configuration bytes are absent and the block never drives them.

Pad inputs are asynchronous. They pass through a two-flop synchronizer before they show in a data register. The block produces one output-enable bit and one output-value bit per pad.

Top module: `gpio_bank_regfile`

## Requirements
- R1: After reset every implemented pin is a non-inverted push-pull input, every configuration byte of an implemented pin reads 0x01, every output latch bit is 0, and pad_oe and pad_out are all zero.
- R2: Bank b (0..5) has its data register at offset 0x4B+b, with pin n of the bank at bit n. Pin p = 8*b+n has its configuration byte at offset 0x10+p.
- R3: In a configuration byte, bit 0 = 1 selects input and bit 0 = 0 selects output. Bit 1 enables inversion and bit 7 selects open-drain. Bits 6..2 always read 0.
- R4: An implemented push-pull output pin has pad_oe = 1 and pad_out = latch XOR invert, from the clock edge that registers the write.
- R5: An implemented open-drain output pin drives low (pad_oe = 1, pad_out = 0) when latch XOR invert is 0, and releases the pad (pad_oe = 0, pad_out = 0) when it is 1.
- R6: An input pin never drives its pad. Its data bit reads pad_in XOR invert, and a pad change shows after exactly two rising clock edges.
- R7: For an output pin, the data bit reads the latch bit as written, whatever the invert setting.
- R8: Unimplemented pins are in banks 1 (pins 0, 3, 4, 5, 6), 2 (pin 5) and 3 (pins 1, 3). Their configuration bytes read 0x00 and ignore writes. Their data bits read 0, and pad_oe and pad_out for them stay 0.
- R9: Offsets outside 0x10..0x3F and 0x4B..0x50 read 0x00, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 8 | Register offset within the runtime window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for addr |
| pad_in | input | 48 | Pad input levels, asynchronous |
| pad_oe | output | 48 | Pad output enable |
| pad_out | output | 48 | Pad output value |

## Verification
The assertions assume three things about the inputs. Reset is low from time zero. wr_en and addr carry known values at each rising edge. pad_in is left unconstrained, since only the synchronizer samples it.

The bench follows these assumptions. It holds reset low at the start and changes every input only on falling edges. After each pad change it waits two edges before it compares a data register. The random writes may hit unimplemented pins and unmapped offsets, so the checks for ignored writes run together with the checks on normal behaviour.

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile #(
  parameter int NBANK = 6,
  parameter logic [7:0] DATA_BASE = 8'h4B,
  parameter logic [7:0] CFG_BASE = 8'h10,
  parameter logic [NBANK*8-1:0] PIN_PRESENT = 48'hFFFF_F5DF_86FF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  input  logic [NBANK*8-1:0] pad_in,
  output logic [NBANK*8-1:0] pad_oe,
  output logic [NBANK*8-1:0] pad_out
);
  localparam int NPIN = NBANK * 8;

  logic [NPIN-1:0] cfg_in, cfg_inv, cfg_od, latch, sync1, sync2, drv, rd_vec;
  logic [8:0] d_off, c_off;
  logic data_hit, cfg_hit;

  assign d_off    = {1'b0, addr} - {1'b0, DATA_BASE};
  assign c_off    = {1'b0, addr} - {1'b0, CFG_BASE};
  assign data_hit = (addr >= DATA_BASE) && (d_off < 9'(NBANK));
  assign cfg_hit  = (addr >= CFG_BASE) && (c_off < 9'(NPIN));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
    end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    if (PIN_PRESENT[i]) begin : g_live
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          cfg_in[i]  <= 1'b1;
          cfg_inv[i] <= 1'b0;
          cfg_od[i]  <= 1'b0;
        end else if (wr_en && cfg_hit && c_off == 9'(i)) begin
          cfg_in[i]  <= wdata[0];
          cfg_inv[i] <= wdata[1];
          cfg_od[i]  <= wdata[7];
        end

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)
          latch[i] <= 1'b0;
        else if (wr_en && data_hit && d_off == 9'(i / 8))
          latch[i] <= wdata[i % 8];

      assign drv[i]     = latch[i] ^ cfg_inv[i];
      assign rd_vec[i]  = cfg_in[i] ? (sync2[i] ^ cfg_inv[i]) : latch[i];
      assign pad_oe[i]  = !cfg_in[i] && (cfg_od[i] ? !drv[i] : 1'b1);
      assign pad_out[i] = !cfg_in[i] && !cfg_od[i] && drv[i];
    end else begin : g_absent
      assign cfg_in[i]  = 1'b0;
      assign cfg_inv[i] = 1'b0;
      assign cfg_od[i]  = 1'b0;
      assign latch[i]   = 1'b0;
      assign drv[i]     = 1'b0;
      assign rd_vec[i]  = 1'b0;
      assign pad_oe[i]  = 1'b0;
      assign pad_out[i] = 1'b0;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (data_hit)
      for (int b = 0; b < NBANK; b++)
        if (d_off == 9'(b)) rdata = rd_vec[b*8 +: 8];
    if (cfg_hit)
      for (int i = 0; i < NPIN; i++)
        if (c_off == 9'(i))
          rdata = {cfg_od[i], 5'b0, cfg_inv[i], cfg_in[i]} & {8{PIN_PRESENT[i]}};
  end
endmodule

// File: rtl/gpio_bank_regfile_chk.sv
module gpio_bank_regfile_chk #(
  parameter int NBANK = 6,
  parameter logic [7:0] DATA_BASE = 8'h4B,
  parameter logic [7:0] CFG_BASE = 8'h10,
  parameter logic [NBANK*8-1:0] PIN_PRESENT = 48'hFFFF_F5DF_86FF
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [7:0]         addr,
  input logic [7:0]         rdata,
  input logic [NBANK*8-1:0] pad_oe,
  input logic [NBANK*8-1:0] pad_out
);
  localparam int NPIN = NBANK * 8;

  logic in_cfg, in_data;
  assign in_cfg  = int'(addr) >= int'(CFG_BASE) && int'(addr) < int'(CFG_BASE) + NPIN;
  assign in_data = int'(addr) >= int'(DATA_BASE) && int'(addr) < int'(DATA_BASE) + NBANK;

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> pad_oe == '0);

  a_r8_absent_never_driven: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_out) & ~PIN_PRESENT) == '0);

  a_r5_no_high_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  a_r3_cfg_gap_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_cfg |-> rdata[6:2] == 5'b0);

  a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_cfg && !in_data) |-> rdata == 8'h00);

  a_r4_pads_move_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> ($stable(pad_oe) && $stable(pad_out)));
endmodule

bind gpio_bank_regfile gpio_bank_regfile_chk #(
  .NBANK(NBANK), .DATA_BASE(DATA_BASE), .CFG_BASE(CFG_BASE), .PIN_PRESENT(PIN_PRESENT)
) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .rdata(rdata),
  .pad_oe(pad_oe), .pad_out(pad_out)
);

// File: tb/test_gpio_bank_regfile.sv
module test_gpio_bank_regfile;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] PRES = 48'hFFFF_F5DF_86FF;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
  logic [47:0] pad_in = '0, pad_oe, pad_out;

  logic [47:0] m_in, m_inv, m_od, m_latch;
  int n_run = 0, n_fail = 0;
  logic finished = 1'b0;

  gpio_bank_regfile i_gpio_bank_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] exp_oe();
    for (int i = 0; i < 48; i++)
      exp_oe[i] = PRES[i] && !m_in[i] && (m_od[i] ? !(m_latch[i] ^ m_inv[i]) : 1'b1);
  endfunction

  function automatic logic [47:0] exp_out();
    for (int i = 0; i < 48; i++)
      exp_out[i] = PRES[i] && !m_in[i] && !m_od[i] && (m_latch[i] ^ m_inv[i]);
  endfunction

  function automatic logic [7:0] exp_data(input int b);
    for (int n = 0; n < 8; n++) begin
      int i = b*8 + n;
      exp_data[n] = !PRES[i] ? 1'b0 : m_in[i] ? (pad_in[i] ^ m_inv[i]) : m_latch[i];
    end
  endfunction

  function automatic logic [7:0] exp_cfg(input int i);
    exp_cfg = PRES[i] ? {m_od[i], 5'b0, m_inv[i], m_in[i]} : 8'h00;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a >= 8'h4B && a <= 8'h50)
      for (int n = 0; n < 8; n++) begin
        int i = (int'(a) - 'h4B)*8 + n;
        if (PRES[i]) m_latch[i] = d[n];
      end
    else if (a >= 8'h10 && a <= 8'h3F && PRES[int'(a) - 'h10]) begin
      m_in[int'(a) - 'h10] = d[0];
      m_inv[int'(a) - 'h10] = d[1];
      m_od[int'(a) - 'h10] = d[7];
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic check_all(input string req);
    logic [7:0] v;
    chk(req, 64'(pad_oe), 64'(exp_oe()));
    chk(req, 64'(pad_out), 64'(exp_out()));
    for (int b = 0; b < 6; b++) begin
      rd(8'(8'h4B + b), v);
      chk(req, 64'(v), 64'(exp_data(b)));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5eed_0017));
    m_in = PRES; m_inv = '0; m_od = '0; m_latch = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 oe", 64'(pad_oe), 64'h0);
    chk("R1 out", 64'(pad_out), 64'h0);
    rd(8'h10, v); chk("R1 cfg pin0", 64'(v), 64'h01);
    rd(8'h4B, v); chk("R1 data bank0", 64'(v), 64'h00);

    // R8 absent cfg reads zero and ignores writes
    rd(8'h18, v); chk("R8 absent cfg", 64'(v), 64'h00);
    wr(8'h18, 8'h00); wr(8'h4C, 8'hFF);
    rd(8'h18, v); chk("R8 absent cfg after write", 64'(v), 64'h00);
    chk("R8 bank1 oe", 64'(pad_oe[15:8]), 64'h0);

    // R2/R4 push-pull output on pin 0
    wr(8'h10, 8'h00); wr(8'h4B, 8'h01);
    chk("R4 pp oe", 64'(pad_oe[0]), 64'h1);
    chk("R4 pp out", 64'(pad_out[0]), 64'h1);
    rd(8'h10, v); chk("R3 cfg readback", 64'(v), 64'h00);

    // R7 inversion: drive complemented, read latch as written
    wr(8'h10, 8'h7E);
    chk("R4 inverted out", 64'(pad_out[0]), 64'h0);
    rd(8'h10, v); chk("R3 gap bits", 64'(v), 64'h02);
    rd(8'h4B, v); chk("R7 latch read", 64'(v[0]), 64'h1);

    // R5 open-drain
    wr(8'h10, 8'h80);
    chk("R5 od release oe", 64'(pad_oe[0]), 64'h0);
    chk("R5 od release out", 64'(pad_out[0]), 64'h0);
    wr(8'h4B, 8'h00);
    chk("R5 od low oe", 64'(pad_oe[0]), 64'h1);
    chk("R5 od low out", 64'(pad_out[0]), 64'h0);

    // R6 synchronizer latency on pin 1 (default input)
    pad_in[1] = 1'b1;
    #1 rd(8'h4B, v); chk("R6 before edges", 64'(v[1]), 64'h0);
    @(negedge clk); rd(8'h4B, v); chk("R6 after one edge", 64'(v[1]), 64'h0);
    @(negedge clk); rd(8'h4B, v); chk("R6 after two edges", 64'(v[1]), 64'h1);
    chk("R6 input not driven", 64'(pad_oe[1]), 64'h0);

    // R9 unmapped offset
    wr(8'h00, 8'hFF); wr(8'h4A, 8'hFF); wr(8'h51, 8'hFF);
    rd(8'h00, v); chk("R9 unmapped read", 64'(v), 64'h00);
    rd(8'hFF, v); chk("R9 unmapped read ff", 64'(v), 64'h00);
    @(negedge clk);
    check_all("R9 state unchanged");

    // Random mix: R2 R3 R4 R5 R6 R7 R8 R9
    for (int k = 0; k < 400; k++) begin
      int sel = int'($urandom_range(0, 9));
      if (sel < 4) wr(8'(8'h10 + $urandom_range(0, 47)), 8'($urandom));
      else if (sel < 7) wr(8'(8'h4B + $urandom_range(0, 5)), 8'($urandom));
      else if (sel < 8) begin
        logic [7:0] a;
        do a = 8'($urandom); while ((a >= 8'h10 && a <= 8'h3F) || (a >= 8'h4B && a <= 8'h50));
        wr(a, 8'($urandom));
      end else begin
        @(negedge clk);
        pad_in = {16'($urandom), 32'($urandom)};
        @(negedge clk); @(negedge clk);
      end
      check_all("R2 random data/pads");
      begin
        int p = int'($urandom_range(0, 47));
        rd(8'(8'h10 + p), v);
        chk("R3 random cfg", 64'(v), 64'(exp_cfg(p)));
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule